// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Bit-Slip Alignment

This block gathers a retimed serial bit stream into 16-bit parallel words. It runs entirely on the serial-rate clock and derives a word-rate clock, `word_clk`, at one sixteenth of that rate. The serial bit is taken from one of two sources: the normal receive input, or a loopback input that is used for diagnostic tests of the whole path.

Framing is adjusted by an alignment request. `align_req` passes through a two-stage synchroniser, and its high time is measured. A request that stays high long enough causes exactly one serial bit to be discarded at the next word boundary. This moves the word framing by one position. Upstream framing logic issues one request after another until the word boundary lands where it wants it.

Top module: `bitstream_deser`

## Requirements
- R1: While `rst` is sampled high at a clock edge, `word_out` is cleared to 0 and `word_clk` is low after that edge.
- R2: After reset, the first 16 serial bits form the first word. The first bit received goes to `word_out[15]` and the sixteenth goes to `word_out[0]`. The word appears after the 16th clock edge.
- R3: Without a slip, each later word is the next 16 contiguous serial bits and appears exactly 16 serial clocks after the previous word.
- R4: `path_sel` = 0 takes the serial bit from `main_bit`, and `path_sel` = 1 takes it from `loop_bit`. The unselected input has no effect on `word_out`.
- R5: Within each 16-bit word period, `word_clk` is low while the first 8 bits of the word are consumed and high while the last 8 are consumed. `word_out` changes only at an edge where `word_clk` falls.
- R6: `align_req` is accepted only if it is sampled high on at least 4 consecutive clock edges. Pulses of 1 to 3 samples leave the framing unchanged.
- R7: An accepted request drops one bit: the bit presented at the first word boundary at or after the second clock edge following the 4th high sample. That bit never enters a word, and the following words are shifted by one bit. The word period holding the drop lasts 17 clocks, with `word_clk` low for 9 of them.
- R8: Each accepted pulse drops exactly one bit, however long `align_req` stays high.
- R9: The stretched 9-clock low phase of `word_clk` completes within 32 serial clocks (two word periods) of the first high sample of an accepted pulse.
- R10: A reset in the middle of a stream discards any partial word and any pending slip, and framing restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| main_bit | input | 1 | Normal serial data input |
| loop_bit | input | 1 | Loopback serial data input |
| path_sel | input | 1 | Source select: 0 normal, 1 loopback |
| align_req | input | 1 | Asynchronous alignment request, qualified by pulse width |
| word_out | output | 16 | Parallel word, first-received bit in bit 15 |
| word_clk | output | 1 | Word-rate clock; `word_out` changes on its falling edge |

## Verification
A word is due at the 16th kept bit after reset or after the previous word. The bench recomputes this from its own count of bits kept, and compares `word_out` and `word_clk` half a clock after every edge. An accepted request is predicted to drop a bit at the first word boundary two or more edges after the fourth high sample, so every check after that point reflects the shifted framing. The R9 bound is measured at the ports: the bench counts the clocks from the first high sample of the request to the end of the 9-clock low phase of `word_clk`. The count of such long low phases must equal the number of predicted slips. Request pulses are swept across all 16 word phases, and pulses of 1 to 3 samples and a long-held pulse are also applied.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // Next bit index inside a word of w bits, wrapping at the last position.
  function automatic int unsigned next_index(input int unsigned c, input int unsigned w);
    return (c + 1 == w) ? 0 : c + 1;
  endfunction

  // Word clock level: high once the second half of the word is being consumed.
  function automatic logic upper_half(input int unsigned c, input int unsigned w);
    return c >= (w / 2);
  endfunction

  // Saturating increment of a pulse-width count.
  function automatic int unsigned sat_inc(input int unsigned c, input int unsigned lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

endpackage

// File: rtl/sync_qualifier.sv
module sync_qualifier #(
  parameter int unsigned STAGES   = 2,
  parameter int unsigned MIN_HIGH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  output logic accept_o
);
  localparam int HW = $clog2(MIN_HIGH + 1);
  localparam logic [HW-1:0] FIRE_AT = HW'(MIN_HIGH - 1);

  logic [STAGES-1:0] meta;
  logic              prev_lvl;
  logic [HW-1:0]     hi_cnt;
  logic              sync_lvl;
  logic              sync_rise;

  always_ff @(posedge clk) begin
    if (rst) meta <= '0;
    else     meta <= {meta[STAGES-2:0], req_in};
  end

  assign sync_lvl  = meta[STAGES-1];
  assign sync_rise = sync_lvl & ~prev_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      hi_cnt   <= '0;
    end else begin
      prev_lvl <= sync_lvl;
      if (!sync_lvl) hi_cnt <= '0;
      else           hi_cnt <= HW'(deser_pkg::sat_inc(int'(hi_cnt), MIN_HIGH));
    end
  end

  assign accept_o = sync_lvl && (hi_cnt == FIRE_AT);

  // Checker state: a pulse already produced its acceptance.
  logic taken;
  always_ff @(posedge clk) begin
    if (rst)            taken <= 1'b0;
    else if (!sync_lvl) taken <= 1'b0;
    else if (accept_o)  taken <= 1'b1;
  end

  assert_one_per_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> !taken);

  assert_rise_restarts_R6: assert property (@(posedge clk) disable iff (rst)
    sync_rise |-> (hi_cnt == '0));

  generate
    if (MIN_HIGH >= 4) begin : g_width_chk
      assert_short_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> ($past(sync_lvl, 1) && $past(sync_lvl, 2) && $past(sync_lvl, 3)));
    end
  endgenerate

endmodule

// File: rtl/bit_framer.sv
module bit_framer #(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  output logic drop_o,
  output logic done_o,
  output logic word_clk_o
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0] cnt;
  logic          pending;
  logic          slip_want;

  assign slip_want  = pending | accept_i;
  assign drop_o     = slip_want && (cnt == '0);
  assign done_o     = !drop_o && (cnt == LAST);
  assign word_clk_o = deser_pkg::upper_half(int'(cnt), WORD_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      pending <= slip_want & ~drop_o;
      if (!drop_o) cnt <= CW'(deser_pkg::next_index(int'(cnt), WORD_W));
    end
  end

  // Checker: how long a slip has been waiting for a word boundary.
  logic [CW:0] pend_age;
  always_ff @(posedge clk) begin
    if (rst)          pend_age <= '0;
    else if (pending) pend_age <= pend_age + (CW+1)'(1);
    else              pend_age <= '0;
  end

  assert_slip_bounded_R9: assert property (@(posedge clk) disable iff (rst)
    pend_age < (CW+1)'(WORD_W));

  assert_drop_holds_R7: assert property (@(posedge clk) disable iff (rst)
    drop_o |=> ((cnt == '0) && !pending && !word_clk_o));

  assert_word_edge_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> $fell(word_clk_o));

endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_i,
  input  logic              drop_i,
  input  logic              done_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      word_o <= '0;
    end else begin
      if (!drop_i) sh <= {sh[WORD_W-3:0], bit_i};
      if (done_i)  word_o <= {sh, bit_i};
    end
  end

  assert_word_on_done_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_o) |-> $past(done_i));

  assert_drop_discards_R7: assert property (@(posedge clk) disable iff (rst)
    drop_i |=> $stable(sh));

endmodule

// File: rtl/bitstream_deser.sv
module bitstream_deser #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_HIGH    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              main_bit,
  input  logic              loop_bit,
  input  logic              path_sel,
  input  logic              align_req,
  output logic [WORD_W-1:0] word_out,
  output logic              word_clk
);
  logic serial_bit;
  logic slip_accept;
  logic bit_drop;
  logic word_done;

  assign serial_bit = path_sel ? loop_bit : main_bit;

  sync_qualifier #(
    .STAGES  (SYNC_STAGES),
    .MIN_HIGH(MIN_HIGH)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .req_in  (align_req),
    .accept_o(slip_accept)
  );

  bit_framer #(
    .WORD_W(WORD_W)
  ) u_framer (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (slip_accept),
    .drop_o    (bit_drop),
    .done_o    (word_done),
    .word_clk_o(word_clk)
  );

  word_shifter #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk   (clk),
    .rst   (rst),
    .bit_i (serial_bit),
    .drop_i(bit_drop),
    .done_i(word_done),
    .word_o(word_out)
  );

  assert_src_sel_R4: assert property (@(posedge clk) disable iff (rst)
    word_done |=> (word_out[0] == $past(path_sel ? loop_bit : main_bit)));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> ((word_out == '0) && !word_clk));

endmodule

// File: tb/test_bitstream_deser.sv
`timescale 1ns/1ps
module test_bitstream_deser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        main_bit = 1'b0;
  logic        loop_bit = 1'b0;
  logic        path_sel = 1'b0;
  logic        align_req = 1'b0;
  logic [15:0] word_out;
  logic        word_clk;

  bitstream_deser i_bitstream_deser (
    .clk      (clk),
    .rst      (rst),
    .main_bit (main_bit),
    .loop_bit (loop_bit),
    .path_sel (path_sel),
    .align_req(align_req),
    .word_out (word_out),
    .word_clk (word_clk)
  );

  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // Bench model state
  int          kept = 0;
  int          edge_n = 0;
  int          run = 0;
  int          rise_edge = 0;
  int          armed = 0;
  int          arm_edge = 0;
  int          drops = 0;
  int          lowrun = 0;
  int          long_lows = 0;
  logic        wb [16];
  logic [15:0] exp_word = '0;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    kept = 0; run = 0; armed = 0; lowrun = 0; exp_word = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; align_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(word_out == 16'h0, "R1", "word_out after reset", word_out, 0);
    check(word_clk == 1'b0, "R1", "word_clk after reset", word_clk, 0);
    rst = 1'b0;
    model_reset();
  endtask

  // One serial clock: drive inputs, predict, then check after the edge.
  task automatic step(input logic a, input string req);
    logic m, l, sel;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    m = lf[0];
    l = lf[7] ^ lf[3];
    main_bit = m; loop_bit = l; align_req = a;
    sel = path_sel ? l : m;
    if (a) begin
      run++;
      if (run == 1) rise_edge = edge_n;
    end else run = 0;
    if (run == 4) begin armed = 1; arm_edge = edge_n + 2; end
    if (armed != 0 && edge_n >= arm_edge && (kept % 16) == 0) begin
      armed = 0; drops++;
    end else begin
      wb[kept % 16] = sel;
      kept++;
      if ((kept % 16) == 0) begin
        int v = 0;
        for (int i = 0; i < 16; i++) if (wb[i]) v += (1 << (15 - i));
        exp_word = 16'(v);
      end
    end
    @(negedge clk);
    check(word_out == exp_word, req, "word_out", word_out, exp_word);
    check(word_clk == ((kept % 16) >= 8), "R5", "word_clk", word_clk,
          int'((kept % 16) >= 8));
    if (!word_clk) lowrun++; else lowrun = 0;
    if (lowrun == 9) begin
      long_lows++;
      // R9: stretched low phase complete within two word periods
      check((edge_n - rise_edge) <= 32, "R9", "slip latency",
            edge_n - rise_edge, 32);
    end
    edge_n++;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R2 R3: normal input, contiguous words
    path_sel = 1'b0;
    for (int k = 0; k < 64; k++) step(1'b0, "R3");
    // R4: loopback source selected
    path_sel = 1'b1;
    for (int k = 0; k < 64; k++) step(1'b0, "R4");
    path_sel = 1'b0;
    // R6: short pulses at several phases leave framing alone
    for (int len = 1; len <= 3; len++) begin
      for (int ph = 0; ph < 16; ph += 5) begin
        while ((kept % 16) != ph) step(1'b0, "R6");
        for (int k = 0; k < len; k++) step(1'b1, "R6");
        for (int k = 0; k < 30; k++) step(1'b0, "R6");
      end
    end
    check(long_lows == 0, "R6", "slips from short pulses", long_lows, 0);
    // R7 R9: minimum-width pulse swept over every word phase
    for (int ph = 0; ph < 16; ph++) begin
      path_sel = ph[0];
      while ((kept % 16) != ph) step(1'b0, "R7");
      for (int k = 0; k < 4; k++) step(1'b1, "R7");
      for (int k = 0; k < 40; k++) step(1'b0, "R7");
    end
    check(long_lows == 16, "R7", "slips from sweep", long_lows, 16);
    // R8: long pulse yields a single slip
    path_sel = 1'b1;
    for (int k = 0; k < 60; k++) step(1'b1, "R8");
    for (int k = 0; k < 40; k++) step(1'b0, "R8");
    check(long_lows == 17, "R8", "slips after long pulse", long_lows, 17);
    check(long_lows == drops, "R8", "slips vs predicted", long_lows, drops);
    // R10: reset mid-word with a slip pending
    path_sel = 1'b0;
    while ((kept % 16) != 3) step(1'b0, "R10");
    for (int k = 0; k < 5; k++) step(1'b1, "R10");
    do_reset();
    for (int k = 0; k < 48; k++) step(1'b0, "R10");
    check(long_lows == 17, "R10", "slip cancelled by reset", long_lows, 17);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule